// File: doc/BRIEF.md
# Opcode-Driven Transmit DMA Sequencer

This block feeds a serial-bus protocol controller from a command table in memory. The table is a run of command bytes. Some command bytes carry one data byte straight after them. When software has loaded a start address and a transaction count and set the enable bit, the sequencer waits for the controller's transmit-ready flag. It then fetches one command byte and writes it to the controller's command register. If the command carries data, it fetches the following byte and writes it to the data register. It then acknowledges the ready flag so that the controller clears it.

Every byte moved advances the address pointer by one and lowers the remaining-transaction counter by one. When the final request completes, a sticky end-of-block flag is raised and the enable bit drops by itself. In suspend mode, a protocol error or a lost arbitration freezes fetching until the condition clears. The sequencer keeps its place across any wait: a delayed memory grant, a suspend, or software clearing the enable bit.

Top module: `tx_dma_seq`

## Requirements
- R1: A new request starts only when the enable bit is 1, `tx_ready` is 1 and the counter is nonzero. With the enable bit at 0, no memory request and no write strobe occur.
- R2: The low three bits of a fetched command byte set the size of the request. Codes 1 through 5 move two bytes (command, then data). Codes 0, 6 and 7 move the command byte alone.
- R3: A command byte is written with `cmd_we` and a data byte with `dat_we`, each for one cycle, never both in the same cycle. `wr_data` equals the byte read. A data write always follows the command byte that needs it.
- R4: Each byte written raises `ptr_o` by one and lowers `cnt_o` by one. `cnt_o` holds at zero instead of wrapping.
- R5: `ready_ack` pulses once per completed request, in the cycle of that request's last byte write, and at no other time.
- R6: If the counter reaches zero on a command byte that carries data, the data byte is still fetched and written before the block ends.
- R7: When a request completes with the counter at zero, `eob_o` is set and the enable bit is cleared in the same step. `eob_o` stays set until `eob_clr` is pulsed.
- R8: When `susp_mode` is 1 and `proto_err` or `arb_lost` is 1, `mem_req` stays low. When `susp_mode` is 0, those two inputs have no effect on transfers.
- R9: `en_set` while `cnt_o` is zero leaves the enable bit at 0.
- R10: If the enable bit is cleared between the command and data bytes, no further write happens. When the bit is set again, the sequencer resumes with the pending data byte from the unchanged pointer.
- R11: A memory read is granted when `mem_req` and `mem_gnt` are both 1 on a rising edge. Read data is taken when `mem_rvalid` is 1, one cycle later. `mem_addr` equals `ptr_o` and holds steady while a request waits for its grant.
- R12: After reset, the enable bit and `eob_o` are 0 and no request or strobe is active. A `cfg_load` pulse sets `ptr_o` to `cfg_base` and `cnt_o` to `cfg_count`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_load | input | 1 | Load pointer and counter |
| cfg_base | input | AW | Table start address |
| cfg_count | input | CW | Number of transactions |
| en_set | input | 1 | Software sets the enable bit |
| en_clr | input | 1 | Software clears the enable bit |
| eob_clr | input | 1 | Write-one clear of the end-of-block flag |
| susp_mode | input | 1 | 1: pause on error or lost arbitration |
| proto_err | input | 1 | Protocol error flag |
| arb_lost | input | 1 | Arbitration lost flag |
| tx_ready | input | 1 | Controller transmit-ready flag |
| ready_ack | output | 1 | Request done; controller clears ready |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | AW | Memory read address |
| mem_gnt | input | 1 | Memory grant |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 8 | Read data |
| cmd_we | output | 1 | Command register write strobe |
| dat_we | output | 1 | Data register write strobe |
| wr_data | output | 8 | Write data to the controller |
| en_o | output | 1 | Enable bit |
| eob_o | output | 1 | End-of-block flag |
| ptr_o | output | AW | Address pointer |
| cnt_o | output | CW | Remaining transactions |

## Verification
A table of random command bytes is streamed under random grant delays, random ready timing and random error flags. Every strobe is compared with a byte-by-byte walk of the table. A design that misreads the command code would write a command byte where data belongs, or drop a data byte. One that ends on the counter alone would skip the final data byte when a one-transaction block holds a data-carrying command. Disabling between the two bytes of a request would expose a sequencer that loses its phase: after re-enable it would send the data byte to the command register. Suspend runs with a flag held high would expose any memory request issued while paused. An enable attempt with a zero count would show an enable bit that latches anyway.

// File: rtl/txdma_pkg.sv
package txdma_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_REQ, ST_RD} seq_st_e;

  // command codes 1..5 are followed by a data byte
  function automatic logic code_has_data(input logic [2:0] code);
    return (code >= 3'd1) && (code <= 3'd5);
  endfunction
endpackage

// File: rtl/tx_dma_ptrcnt.sv
module tx_dma_ptrcnt #(
  parameter int AW = 16,
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] base,
  input  logic [CW-1:0] count,
  input  logic          step,
  output logic [AW-1:0] ptr,
  output logic [CW-1:0] cnt,
  output logic          cnt_zero,
  output logic          cnt_le1
);
  localparam logic [CW-1:0] CNT_ONE = CW'(1);

  logic [AW-1:0] ptr_q, ptr_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          upd;

  always_comb begin
    upd   = load | step;
    ptr_d = ptr_q;
    cnt_d = cnt_q;
    if (load) begin
      ptr_d = base;
      cnt_d = count;
    end else if (step) begin
      ptr_d = ptr_q + AW'(1);
      cnt_d = (cnt_q == '0) ? '0 : cnt_q - CNT_ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
      cnt_q <= '0;
    end else if (upd) begin
      ptr_q <= ptr_d;
      cnt_q <= cnt_d;
    end
  end

  assign ptr      = ptr_q;
  assign cnt      = cnt_q;
  assign cnt_zero = (cnt_q == '0);
  assign cnt_le1  = (cnt_q <= CNT_ONE);
endmodule

// File: rtl/tx_dma_ctl.sv
module tx_dma_ctl
  import txdma_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en_set,
  input  logic       en_clr,
  input  logic       eob_clr,
  input  logic       susp_mode,
  input  logic       proto_err,
  input  logic       arb_lost,
  input  logic       tx_ready,
  input  logic       cnt_zero,
  input  logic       cnt_le1,
  input  logic       mem_gnt,
  input  logic       mem_rvalid,
  input  logic [2:0] rd_code,
  output logic       mem_req,
  output logic       cmd_we,
  output logic       dat_we,
  output logic       step,
  output logic       ready_ack,
  output logic       en_o,
  output logic       eob_o
);
  seq_st_e st_q, st_d;
  logic    ph_q, ph_d;     // 1: data byte pending
  logic    en_q, en_d;
  logic    eob_q, eob_d;
  logic    hold, last, eob_fire;

  assign hold = !en_q | (susp_mode & (proto_err | arb_lost));

  always_comb begin
    st_d      = st_q;
    ph_d      = ph_q;
    mem_req   = 1'b0;
    cmd_we    = 1'b0;
    dat_we    = 1'b0;
    step      = 1'b0;
    last      = 1'b0;
    ready_ack = 1'b0;
    eob_fire  = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (tx_ready && !cnt_zero && !hold) begin
          st_d = ST_REQ;
          ph_d = 1'b0;
        end
      end
      ST_REQ: begin
        if (!hold) begin
          mem_req = 1'b1;
          if (mem_gnt) st_d = ST_RD;
        end
      end
      ST_RD: begin
        if (mem_rvalid) begin
          if (!en_q) begin
            st_d = ST_REQ;              // refetch same byte later
          end else begin
            step = 1'b1;
            if (!ph_q) begin
              cmd_we = 1'b1;
              if (code_has_data(rd_code)) begin
                ph_d = 1'b1;
                st_d = ST_REQ;
              end else begin
                last = 1'b1;
              end
            end else begin
              dat_we = 1'b1;
              last   = 1'b1;
            end
            if (last) begin
              ready_ack = 1'b1;
              eob_fire  = cnt_le1;
              st_d      = ST_IDLE;
              ph_d      = 1'b0;
            end
          end
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_comb begin
    en_d = en_q;
    if (en_set && !cnt_zero) en_d = 1'b1;
    if (en_clr || eob_fire)  en_d = 1'b0;
    eob_d = eob_q;
    if (eob_clr)  eob_d = 1'b0;
    if (eob_fire) eob_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      ph_q  <= 1'b0;
      en_q  <= 1'b0;
      eob_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      ph_q  <= ph_d;
      en_q  <= en_d;
      eob_q <= eob_d;
    end
  end

  assign en_o  = en_q;
  assign eob_o = eob_q;
endmodule

// File: rtl/tx_dma_seq.sv
module tx_dma_seq #(
  parameter int AW = 16,
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_load,
  input  logic [AW-1:0] cfg_base,
  input  logic [CW-1:0] cfg_count,
  input  logic          en_set,
  input  logic          en_clr,
  input  logic          eob_clr,
  input  logic          susp_mode,
  input  logic          proto_err,
  input  logic          arb_lost,
  input  logic          tx_ready,
  output logic          ready_ack,
  output logic          mem_req,
  output logic [AW-1:0] mem_addr,
  input  logic          mem_gnt,
  input  logic          mem_rvalid,
  input  logic [7:0]    mem_rdata,
  output logic          cmd_we,
  output logic          dat_we,
  output logic [7:0]    wr_data,
  output logic          en_o,
  output logic          eob_o,
  output logic [AW-1:0] ptr_o,
  output logic [CW-1:0] cnt_o
);
  logic step, cnt_zero, cnt_le1;

  tx_dma_ptrcnt #(.AW(AW), .CW(CW)) u_ptrcnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (cfg_load),
    .base     (cfg_base),
    .count    (cfg_count),
    .step     (step),
    .ptr      (ptr_o),
    .cnt      (cnt_o),
    .cnt_zero (cnt_zero),
    .cnt_le1  (cnt_le1)
  );

  tx_dma_ctl u_ctl (
    .clk        (clk),
    .rst_n      (rst_n),
    .en_set     (en_set),
    .en_clr     (en_clr),
    .eob_clr    (eob_clr),
    .susp_mode  (susp_mode),
    .proto_err  (proto_err),
    .arb_lost   (arb_lost),
    .tx_ready   (tx_ready),
    .cnt_zero   (cnt_zero),
    .cnt_le1    (cnt_le1),
    .mem_gnt    (mem_gnt),
    .mem_rvalid (mem_rvalid),
    .rd_code    (mem_rdata[2:0]),
    .mem_req    (mem_req),
    .cmd_we     (cmd_we),
    .dat_we     (dat_we),
    .step       (step),
    .ready_ack  (ready_ack),
    .en_o       (en_o),
    .eob_o      (eob_o)
  );

  assign mem_addr = ptr_o;
  assign wr_data  = mem_rdata;
endmodule

// File: rtl/tx_dma_seq_chk.sv
module tx_dma_seq_chk #(
  parameter int AW = 16,
  parameter int CW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cfg_load,
  input logic          en_set,
  input logic          susp_mode,
  input logic          proto_err,
  input logic          arb_lost,
  input logic          mem_req,
  input logic          mem_gnt,
  input logic [AW-1:0] mem_addr,
  input logic          cmd_we,
  input logic          dat_we,
  input logic          ready_ack,
  input logic          en_o,
  input logic          eob_o,
  input logic [CW-1:0] cnt_o
);
  assert_single_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_we && dat_we));

  assert_suspend_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (susp_mode && (proto_err || arb_lost)) |-> !mem_req);

  assert_no_write_disabled_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_we || dat_we) |-> en_o);

  assert_ack_with_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ready_ack |-> (cmd_we || dat_we));

  assert_eob_disables_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(eob_o) |-> !en_o);

  assert_cnt_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_load && (cmd_we || dat_we) && cnt_o != '0) |=> (cnt_o == $past(cnt_o) - CW'(1)));

  assert_zero_enable_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_o && en_set && cnt_o == '0 && !cfg_load) |=> !en_o);

  assert_addr_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_gnt && !cfg_load) |=> $stable(mem_addr));
endmodule

bind tx_dma_seq tx_dma_seq_chk #(.AW(AW), .CW(CW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cfg_load  (cfg_load),
  .en_set    (en_set),
  .susp_mode (susp_mode),
  .proto_err (proto_err),
  .arb_lost  (arb_lost),
  .mem_req   (mem_req),
  .mem_gnt   (mem_gnt),
  .mem_addr  (mem_addr),
  .cmd_we    (cmd_we),
  .dat_we    (dat_we),
  .ready_ack (ready_ack),
  .en_o      (en_o),
  .eob_o     (eob_o),
  .cnt_o     (cnt_o)
);

// File: tb/tb_tx_dma_seq.sv
`timescale 1ns/1ps
module tb_tx_dma_seq;
  localparam int AW = 16;
  localparam int CW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_load = 1'b0, en_set = 1'b0, en_clr = 1'b0, eob_clr = 1'b0;
  logic [AW-1:0] cfg_base = '0;
  logic [CW-1:0] cfg_count = '0;
  logic susp_mode = 1'b0, proto_err = 1'b0, arb_lost = 1'b0;
  logic tx_ready, ready_ack;
  logic mem_req, mem_gnt, mem_rvalid;
  logic [AW-1:0] mem_addr, ptr_o;
  logic [7:0] mem_rdata, wr_data;
  logic cmd_we, dat_we, en_o, eob_o;
  logic [CW-1:0] cnt_o;

  always #4 clk = ~clk;   // 125 MHz

  tx_dma_seq #(.AW(AW), .CW(CW)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_base(cfg_base),
    .cfg_count(cfg_count), .en_set(en_set), .en_clr(en_clr), .eob_clr(eob_clr),
    .susp_mode(susp_mode), .proto_err(proto_err), .arb_lost(arb_lost),
    .tx_ready(tx_ready), .ready_ack(ready_ack), .mem_req(mem_req),
    .mem_addr(mem_addr), .mem_gnt(mem_gnt), .mem_rvalid(mem_rvalid),
    .mem_rdata(mem_rdata), .cmd_we(cmd_we), .dat_we(dat_we), .wr_data(wr_data),
    .en_o(en_o), .eob_o(eob_o), .ptr_o(ptr_o), .cnt_o(cnt_o)
  );

  int tests = 0, fails = 0, cyc = 0;
  logic [7:0] mem [64];
  logic gnt_block = 1'b0, rand_flags = 1'b0;
  int rdy_dly = 0;
  // scoreboard state
  int exp_ptr = 0, n_cmd = 0, n_dat = 0, n_ack = 0;
  logic pend = 1'b0;

  function automatic logic has_data(input logic [7:0] b);
    return (b[2:0] >= 3'd1) && (b[2:0] <= 3'd5);
  endfunction

  // expected result of walking a table: command count, data count, end pointer
  function automatic void walk(input int base, input int count,
                               output int cmds, output int dats, output int endp);
    int p = base, c = count;
    cmds = 0; dats = 0;
    while (c > 0) begin
      logic [7:0] op = mem[p % 64];
      p++; c--; cmds++;
      if (has_data(op)) begin p++; if (c > 0) c--; dats++; end
    end
    endp = p;
  endfunction

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // memory model: random grants, data one cycle after grant
  always @(posedge clk) begin
    if (!rst_n) begin
      mem_gnt <= 1'b0; mem_rvalid <= 1'b0; mem_rdata <= '0;
    end else begin
      mem_gnt    <= !gnt_block && (($urandom % 3) != 0);
      mem_rvalid <= mem_req && mem_gnt;
      mem_rdata  <= mem[mem_addr[5:0]];
    end
  end

  // controller model: ready clears on ack, returns after a random delay
  always @(posedge clk) begin
    if (!rst_n) begin
      tx_ready <= 1'b0; rdy_dly <= 0;
    end else if (ready_ack) begin
      tx_ready <= 1'b0; rdy_dly <= int'($urandom % 4);
    end else if (!tx_ready) begin
      if (rdy_dly == 0) tx_ready <= 1'b1;
      else rdy_dly <= rdy_dly - 1;
    end
  end

  // random protocol flags
  always @(negedge clk) begin
    if (rand_flags) begin
      proto_err <= (($urandom % 5) == 0);
      arb_lost  <= (($urandom % 7) == 0);
    end
  end

  // per-strobe scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      if (cmd_we || dat_we) begin
        chk(!(cmd_we && dat_we), "R3 one strobe", int'(cmd_we) + int'(dat_we), 1);
        chk(dat_we == pend, "R2 byte kind (1=data)", int'(dat_we), int'(pend));
        chk(wr_data == mem[exp_ptr % 64], "R3 written byte", int'(wr_data), int'(mem[exp_ptr % 64]));
        if (cmd_we) begin n_cmd++; pend = has_data(wr_data); end
        else begin n_dat++; pend = 1'b0; end
        exp_ptr++;
      end
      if (ready_ack) n_ack++;
      if (mem_req && mem_gnt && int'(mem_addr) != exp_ptr)
        chk(1'b0, "R11 read address", int'(mem_addr), exp_ptr);
      if (mem_req && susp_mode && (proto_err || arb_lost))
        chk(1'b0, "R8 request while suspended", 1, 0);
      if (!en_o && (cmd_we || dat_we))
        chk(1'b0, "R10 write while disabled", 1, 0);
    end
  end

  // watchdog
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic load_block(input int base, input int count);
    @(negedge clk);
    cfg_base = AW'(base); cfg_count = CW'(count); cfg_load = 1'b1;
    @(negedge clk);
    cfg_load = 1'b0;
    exp_ptr = base; pend = 1'b0; n_cmd = 0; n_dat = 0; n_ack = 0;
    chk(ptr_o == AW'(base) && cnt_o == CW'(count), "R12 load", int'(ptr_o), base);
  endtask

  task automatic pulse_en;
    @(negedge clk); en_set = 1'b1;
    @(negedge clk); en_set = 1'b0;
  endtask

  task automatic wait_eob(input int limit);
    int k = 0;
    while (!eob_o && k < limit) begin @(negedge clk); k++; end
  endtask

  task automatic check_end(input int base, input int count, input string tag);
    int c, d, e;
    walk(base, count, c, d, e);
    chk(eob_o == 1'b1, {tag, " R7 eob set"}, int'(eob_o), 1);
    chk(en_o == 1'b0, {tag, " R7 enable cleared"}, int'(en_o), 0);
    chk(n_cmd == c, {tag, " R2 command count"}, n_cmd, c);
    chk(n_dat == d, {tag, " R2 data count"}, n_dat, d);
    chk(int'(ptr_o) == e, {tag, " R4 end pointer"}, int'(ptr_o), e);
    chk(cnt_o == '0, {tag, " R4 counter zero"}, int'(cnt_o), 0);
    chk(n_ack == c, {tag, " R5 ack count"}, n_ack, c);
    @(negedge clk); eob_clr = 1'b1;
    @(negedge clk); eob_clr = 1'b0;
  endtask

  initial begin
    int base, count;
    void'($urandom(32'd4711));
    for (int i = 0; i < 48; i++) mem[i] = 8'($urandom);
    mem[48] = 8'h13; mem[49] = 8'hA5;                    // R6: one data command
    mem[52] = 8'h21; mem[53] = 8'h5C; mem[54] = 8'h06;  // R10 table
    for (int i = 55; i < 64; i++) mem[i] = 8'h00;

    repeat (3) @(negedge clk);
    chk(!en_o && !eob_o && !mem_req && !cmd_we && !dat_we, "R12 reset state",
        int'(en_o) + int'(eob_o) + int'(mem_req), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1: loaded but not enabled, ready high -> nothing moves
    load_block(0, 3);
    repeat (10) @(negedge clk);
    chk(n_cmd == 0 && !mem_req, "R1 idle without enable", n_cmd, 0);
    pulse_en();
    wait_eob(3000);
    check_end(0, 3, "directed");

    // R9: enable with zero count ignored
    load_block(0, 0);
    pulse_en();
    chk(en_o == 1'b0, "R9 enable ignored at zero count", int'(en_o), 0);
    repeat (5) @(negedge clk);
    chk(n_cmd == 0, "R9 no transfer", n_cmd, 0);

    // R6: count 1 on a data command still moves the data byte
    load_block(48, 1);
    pulse_en();
    wait_eob(3000);
    check_end(48, 1, "R6");
    chk(n_dat == 1, "R6 data byte moved", n_dat, 1);

    // R7: eob stays until cleared
    load_block(6, 2);
    pulse_en();
    wait_eob(3000);
    repeat (8) @(negedge clk);
    chk(eob_o == 1'b1, "R7 eob sticky", int'(eob_o), 1);
    check_end(6, 2, "R7");
    chk(eob_o == 1'b0, "R7 eob cleared", int'(eob_o), 0);

    // R10: disable between command and data, then resume
    load_block(52, 2);
    pulse_en();
    while (!cmd_we) @(negedge clk);
    gnt_block = 1'b1; en_clr = 1'b1;
    @(negedge clk); en_clr = 1'b0;
    gnt_block = 1'b0;
    repeat (20) @(negedge clk);
    chk(n_dat == 0, "R10 no data while disabled", n_dat, 0);
    chk(int'(ptr_o) == 53 && cnt_o == CW'(1), "R10 state held", int'(ptr_o), 53);
    pulse_en();
    wait_eob(3000);
    check_end(52, 2, "R10");

    // R8: suspend mode with error held freezes fetching
    susp_mode = 1'b1; proto_err = 1'b1;
    load_block(10, 3);
    pulse_en();
    repeat (40) @(negedge clk);
    chk(n_cmd == 0, "R8 frozen while suspended", n_cmd, 0);
    proto_err = 1'b0;
    wait_eob(3000);
    check_end(10, 3, "R8 resume");

    // R8: flags ignored when suspend mode is off
    susp_mode = 1'b0; arb_lost = 1'b1; proto_err = 1'b1;
    load_block(20, 4);
    pulse_en();
    wait_eob(3000);
    check_end(20, 4, "R8 not suspended");
    arb_lost = 1'b0; proto_err = 1'b0;

    // random blocks
    rand_flags = 1'b1;
    for (int n = 0; n < 40; n++) begin
      base  = int'($urandom % 16);
      count = 1 + int'($urandom % 12);
      susp_mode = $urandom % 2;
      load_block(base, count);
      pulse_en();
      wait_eob(5000);
      check_end(base, count, "random");
    end
    rand_flags = 1'b0;

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule